// File: doc/BRIEF.md
# Packed Nibble Tag Store Controller

This block owns a small byte-wide tag store in which every 16-byte granule of data address space has a 4-bit tag, two tags sharing each byte. A client issues one command at a time: read one tag, write one tag, write one tag to a pair of neighbouring granules, read or write a 64-bit group of sixteen tags, or paint one tag over a whole zeroing block. The block turns the data address into a tag-store byte index. Where only one nibble changes, it reads the byte, merges the new nibble and writes the byte back, so the other nibble is kept.

Commands that touch several bytes are stepped one byte per clock by a small sequencer. The sequencer raises `busy` while it works and pulses `done` when the command completes. A per-command flag marks regions without tag storage. For such a region, reads return zero and writes are discarded. A misaligned single or pair write is refused with a fault pulse and does not touch the store. Synchronous reset clears the store.

Top module: `tagmc_top`

## Requirements
- R1: The tag byte for data address A is at index A>>5. Within that byte, the granule with A[4]=0 occupies bits [3:0] and the granule with A[4]=1 occupies bits [7:4].
- R2: A single-tag read (op code 0) returns on `rd_tag` the nibble that A[4] selects. The address bits [3:0] are ignored.
- R3: A single write (op 1) or pair write (op 2) with A[3:0] not zero pulses `fault` and `done` on the first clock edge after acceptance and writes nothing.
- R4: A single write (op 1) replaces only the selected nibble and keeps the other nibble of the byte.
- R5: A pair write (op 2) with A[4]=0 writes the byte at A>>5 with the tag in both nibbles.
- R6: A pair write (op 2) with A[4]=1 writes the tag into bits [7:4] of byte A>>5 and into bits [3:0] of the next byte. The other nibble of each of those bytes is kept.
- R7: A group read (op 3) aligns A down to 256 bytes and returns eight bytes on `rd_bulk`. The byte at index k from the aligned base appears in bits [8k+7:8k].
- R8: A group write (op 4) aligns A the same way and stores bits [8k+7:8k] of `cmd_wdata` into the byte at index k from the base.
- R9: A fill (op 5) aligns A down to ZERO_BLK bytes and writes every covered tag byte (ZERO_BLK/32 of them) as the tag repeated in both nibbles.
- R10: With `cmd_notag` set, reads (ops 0 and 3) return zero and writes (ops 1, 2, 4, 5) leave the store unchanged. The command still completes with `done`.
- R11: A command that covers N bytes is accepted when `cmd_valid` is high and `busy` is low. `busy` stays high for N cycles and `done` pulses on the N-th edge after acceptance. `cmd_valid` is ignored while `busy` is high.
- R12: Reset clears `busy`, `done`, `fault`, `rd_tag`, `rd_bulk` and every byte of the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code (0..5) |
| cmd_addr | input | ADDR_W | Data address |
| cmd_tag | input | 4 | Tag for single, pair and fill writes |
| cmd_wdata | input | 64 | Tag group for group write |
| cmd_notag | input | 1 | Region has no tag storage |
| busy | output | 1 | Sequencer is stepping a command |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Alignment fault, pulses with done |
| rd_tag | output | 4 | Result of a single-tag read |
| rd_bulk | output | 64 | Result of a group read |

## Verification
The bench aims at the nibble merge. A write to one granule followed by a write to its neighbour must leave both tags intact. A design that does not read the byte back first would lose the first tag. Odd-address pair writes cross into the next byte, and group and fill commands are given addresses with random low bits. Wrong alignment would therefore show up as tags in the wrong bytes when the whole store is swept with group reads. Further cases cover misaligned writes, which must leave the store untouched, and commands presented while the sequencer is busy, which must not be taken. The no-storage flag must zero every read and drop every write, fill included.

// File: rtl/tagmc_pkg.sv
package tagmc_pkg;

    localparam int GRAN_LG    = 4;
    localparam int BYTE_SHIFT = GRAN_LG + 1;
    localparam int GROUP_N    = 8;

    typedef enum logic [2:0] {
        OP_LD1  = 3'd0,
        OP_ST1  = 3'd1,
        OP_ST2  = 3'd2,
        OP_LDG  = 3'd3,
        OP_STG  = 3'd4,
        OP_FILL = 3'd5
    } tag_op_e;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        tag_op_e    op;
        logic       hi;
        logic [3:0] tag;
        logic       notag;
    } cmd_ctl_t;

    function automatic logic op_writes(tag_op_e op);
        return (op == OP_ST1) || (op == OP_ST2) || (op == OP_STG) || (op == OP_FILL);
    endfunction

    // New byte value for one step of a write command
    function automatic logic [7:0] merge_byte(tag_op_e op, logic hi, logic second,
                                              logic [7:0] old, logic [3:0] tag,
                                              logic [7:0] grp);
        logic [7:0] r;
        case (op)
            OP_ST1:  r = hi ? {tag, old[3:0]} : {old[7:4], tag};
            OP_ST2:  r = !hi ? {tag, tag} : (second ? {old[7:4], tag} : {tag, old[3:0]});
            OP_STG:  r = grp;
            OP_FILL: r = {tag, tag};
            default: r = old;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tagmc_ram.sv
module tagmc_ram #(
    parameter int IDX_W = 7,
    localparam int DEPTH = 2 ** IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] addr,
    output logic [7:0]       rdata,
    input  logic             we,
    input  logic [7:0]       wdata
);
    logic [7:0] mem [DEPTH];

    assign rdata = mem[addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end
endmodule

// File: rtl/tagmc_plan.sv
module tagmc_plan
    import tagmc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int FILL_N = 4,
    parameter int STEP_W = 4,
    localparam int IDX_W = ADDR_W - BYTE_SHIFT
) (
    input  tag_op_e           op,
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  base,
    output logic [STEP_W-1:0] nbytes,
    output logic              misalign
);
    localparam logic [IDX_W-1:0] GRP_MASK  = ~IDX_W'(GROUP_N - 1);
    localparam logic [IDX_W-1:0] FILL_MASK = ~IDX_W'(FILL_N - 1);

    logic [IDX_W-1:0] idx;
    assign idx = addr[ADDR_W-1:BYTE_SHIFT];

    always_comb begin
        base   = idx;
        nbytes = STEP_W'(1);
        case (op)
            OP_ST2:          nbytes = addr[GRAN_LG] ? STEP_W'(2) : STEP_W'(1);
            OP_LDG, OP_STG: begin
                base   = idx & GRP_MASK;
                nbytes = STEP_W'(GROUP_N);
            end
            OP_FILL: begin
                base   = idx & FILL_MASK;
                nbytes = STEP_W'(FILL_N);
            end
            default: ;
        endcase
    end

    assign misalign = ((op == OP_ST1) || (op == OP_ST2)) && (addr[GRAN_LG-1:0] != '0);
endmodule

// File: rtl/tagmc_seq.sv
module tagmc_seq
    import tagmc_pkg::*;
#(
    parameter int IDX_W  = 7,
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  tag_op_e           op,
    input  logic              hi,
    input  logic [3:0]        tag,
    input  logic [63:0]       wdata,
    input  logic              notag,
    input  logic [IDX_W-1:0]  plan_base,
    input  logic [STEP_W-1:0] plan_n,
    input  logic              plan_fault,
    output logic [IDX_W-1:0]  ram_addr,
    input  logic [7:0]        ram_rdata,
    output logic              ram_we,
    output logic [7:0]        ram_wdata,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [3:0]        rd_tag,
    output logic [63:0]       rd_bulk
);
    seq_state_e        state;
    cmd_ctl_t          ctl_q;
    logic [IDX_W-1:0]  base_q;
    logic [STEP_W-1:0] n_q;
    logic [STEP_W-1:0] step_q;
    logic [63:0]       grp_q;
    logic              last;
    logic [5:0]        lane;

    assign busy      = (state == SQ_RUN);
    assign lane      = {step_q[2:0], 3'b000};
    assign last      = (step_q == n_q - STEP_W'(1));
    assign ram_addr  = base_q + IDX_W'(step_q);
    assign ram_we    = busy && op_writes(ctl_q.op) && !ctl_q.notag;
    assign ram_wdata = merge_byte(ctl_q.op, ctl_q.hi, step_q != '0, ram_rdata,
                                  ctl_q.tag, grp_q[lane +: 8]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            ctl_q   <= '0;
            base_q  <= '0;
            n_q     <= '0;
            step_q  <= '0;
            grp_q   <= '0;
            done    <= 1'b0;
            fault   <= 1'b0;
            rd_tag  <= '0;
            rd_bulk <= '0;
        end else begin
            done  <= 1'b0;
            fault <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (cmd_valid) begin
                        if (plan_fault) begin
                            done  <= 1'b1;
                            fault <= 1'b1;
                        end else begin
                            ctl_q  <= '{op: op, hi: hi, tag: tag, notag: notag};
                            base_q <= plan_base;
                            n_q    <= plan_n;
                            step_q <= '0;
                            grp_q  <= wdata;
                            state  <= SQ_RUN;
                            if (op == OP_LDG) rd_bulk <= '0;
                        end
                    end
                end
                SQ_RUN: begin
                    if (ctl_q.op == OP_LD1)
                        rd_tag <= ctl_q.notag ? 4'h0 : (ctl_q.hi ? ram_rdata[7:4] : ram_rdata[3:0]);
                    if (ctl_q.op == OP_LDG)
                        rd_bulk[lane +: 8] <= ctl_q.notag ? 8'h00 : ram_rdata;
                    step_q <= step_q + STEP_W'(1);
                    if (last) begin
                        state <= SQ_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // R11: no completion pulse while stepping
    a_r11_done_idle: assert property (@(posedge clk) disable iff (rst) busy |-> !done);
    // R11: leaving the running state always completes the command
    a_r11_fell_done: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);
    // R9: fill bytes carry the same tag in both nibbles
    a_r9_fill_pair: assert property (@(posedge clk) disable iff (rst)
        (ram_we && ctl_q.op == OP_FILL) |-> (ram_wdata[7:4] == ram_wdata[3:0]));
    // R5: even pair write replicates the tag
    a_r5_even_pair: assert property (@(posedge clk) disable iff (rst)
        (ram_we && ctl_q.op == OP_ST2 && !ctl_q.hi) |-> (ram_wdata == {ctl_q.tag, ctl_q.tag}));
endmodule

// File: rtl/tagmc_top.sv
module tagmc_top
    import tagmc_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int ZERO_BLK = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [3:0]        cmd_tag,
    input  logic [63:0]       cmd_wdata,
    input  logic              cmd_notag,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [3:0]        rd_tag,
    output logic [63:0]       rd_bulk
);
    localparam int IDX_W  = ADDR_W - BYTE_SHIFT;
    localparam int FILL_N = ZERO_BLK / (2 ** BYTE_SHIFT);
    localparam int MAX_N  = (FILL_N > GROUP_N) ? FILL_N : GROUP_N;
    localparam int STEP_W = $clog2(MAX_N + 1);

    tag_op_e           op;
    logic [IDX_W-1:0]  plan_base;
    logic [STEP_W-1:0] plan_n;
    logic              plan_fault;
    logic [IDX_W-1:0]  ram_addr;
    logic [7:0]        ram_rdata;
    logic              ram_we;
    logic [7:0]        ram_wdata;

    assign op = tag_op_e'(cmd_op);

    tagmc_plan #(.ADDR_W(ADDR_W), .FILL_N(FILL_N), .STEP_W(STEP_W)) u_plan (
        .op(op), .addr(cmd_addr), .base(plan_base), .nbytes(plan_n), .misalign(plan_fault)
    );

    tagmc_seq #(.IDX_W(IDX_W), .STEP_W(STEP_W)) u_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .op(op), .hi(cmd_addr[GRAN_LG]),
        .tag(cmd_tag), .wdata(cmd_wdata), .notag(cmd_notag),
        .plan_base(plan_base), .plan_n(plan_n), .plan_fault(plan_fault),
        .ram_addr(ram_addr), .ram_rdata(ram_rdata), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .busy(busy), .done(done), .fault(fault), .rd_tag(rd_tag), .rd_bulk(rd_bulk)
    );

    tagmc_ram #(.IDX_W(IDX_W)) u_ram (
        .clk(clk), .rst(rst), .addr(ram_addr), .rdata(ram_rdata),
        .we(ram_we), .wdata(ram_wdata)
    );

    // R3: a misaligned single or pair write faults at once without starting
    a_r3_fault_now: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && (op == OP_ST1 || op == OP_ST2) && cmd_addr[GRAN_LG-1:0] != '0)
        |=> (fault && done && !busy));
    // R11: the store is written only while a command is being stepped
    a_r11_write_in_run: assert property (@(posedge clk) disable iff (rst) ram_we |-> busy);
endmodule

// File: tb/tagmc_top_test.sv
module tagmc_top_test;
    localparam int AW = 12;
    localparam int ZB = 128;
    localparam int FN = ZB / 32;
    localparam int DEPTH = 128;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [3:0] cmd_tag = '0;
    logic [63:0] cmd_wdata = '0;
    logic cmd_notag = 1'b0;
    logic busy, done, fault;
    logic [3:0] rd_tag;
    logic [63:0] rd_bulk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [7:0] mdl [DEPTH];

    tagmc_top #(.ADDR_W(AW), .ZERO_BLK(ZB)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_tag(cmd_tag), .cmd_wdata(cmd_wdata), .cmd_notag(cmd_notag),
        .busy(busy), .done(done), .fault(fault), .rd_tag(rd_tag), .rd_bulk(rd_bulk)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog got %0d cycles exp below 150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    function automatic int exp_len(input int op, input logic [AW-1:0] a);
        case (op)
            2: return a[4] ? 2 : 1;
            3, 4: return 8;
            5: return FN;
            default: return 1;
        endcase
    endfunction

    function automatic logic [63:0] model_group(input int idx);
        logic [63:0] r;
        int b;
        b = idx & ~7;
        for (int k = 0; k < 8; k++) r[8*k +: 8] = mdl[b + k];
        return r;
    endfunction

    task automatic model_apply(input int op, input logic [AW-1:0] a, input logic [3:0] t,
                               input logic [63:0] w);
        int idx;
        idx = int'(a >> 5);
        case (op)
            1: if (a[4]) mdl[idx][7:4] = t; else mdl[idx][3:0] = t;
            2: if (a[4]) begin
                   mdl[idx][7:4] = t;
                   mdl[(idx + 1) % DEPTH][3:0] = t;
               end else mdl[idx] = {t, t};
            4: for (int k = 0; k < 8; k++) mdl[(idx & ~7) + k] = w[8*k +: 8];
            5: for (int k = 0; k < FN; k++) mdl[(idx & ~(FN - 1)) + k] = {t, t};
            default: ;
        endcase
    endtask

    // Issues one command, waits for done, checks latency, fault and read data
    task automatic run_cmd(input int op, input logic [AW-1:0] a, input logic [3:0] t,
                           input logic [63:0] w, input logic nt);
        logic mis;
        int n, c, idx;
        logic [3:0] etag;
        logic [63:0] egrp;
        idx  = int'(a >> 5);
        mis  = (op == 1 || op == 2) && (a[3:0] != 4'h0);
        n    = mis ? 0 : exp_len(op, a);
        etag = nt ? 4'h0 : (a[4] ? mdl[idx][7:4] : mdl[idx][3:0]);
        egrp = nt ? 64'h0 : model_group(idx);
        if (!mis && !nt) model_apply(op, a, t, w);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_addr = a; cmd_tag = t;
        cmd_wdata = w; cmd_notag = nt;
        @(negedge clk);
        cmd_valid = 1'b0;
        c = 0;
        while (!done && c < 100) begin
            @(negedge clk);
            c++;
        end
        chk(mis ? "R3 latency" : "R11 latency", 64'(c), 64'(n));
        chk("R3 fault", 64'(fault), 64'(mis));
        if (op == 0) chk(nt ? "R10 tag read" : "R2 tag read", 64'(rd_tag), 64'(etag));
        if (op == 3) chk(nt ? "R10 group read" : "R7 group read", rd_bulk, egrp);
    endtask

    task automatic sweep(input string req);
        for (int b = 0; b < DEPTH / 8; b++) begin
            run_cmd(3, AW'(b * 256 + ($urandom % 256)), 4'h0, 64'h0, 1'b0);
            chk(req, rd_bulk, model_group(b * 8));
        end
    endtask

    initial begin
        int op;
        logic [AW-1:0] a;
        int c;
        void'($urandom(32'd20251));
        for (int i = 0; i < DEPTH; i++) mdl[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk("R12 busy", 64'(busy), 64'h0);
        chk("R12 done", 64'(done), 64'h0);
        chk("R12 fault", 64'(fault), 64'h0);
        chk("R12 rd_tag", 64'(rd_tag), 64'h0);
        chk("R12 rd_bulk", rd_bulk, 64'h0);
        sweep("R12 store cleared");

        // R1 R4 neighbouring granules share a byte, both kept
        run_cmd(1, 12'h020, 4'h5, 64'h0, 1'b0);
        run_cmd(1, 12'h030, 4'hA, 64'h0, 1'b0);
        run_cmd(3, 12'h000, 4'h0, 64'h0, 1'b0);
        chk("R1 R4 byte1", 64'(rd_bulk[15:8]), 64'hA5);
        run_cmd(0, 12'h02F, 4'h0, 64'h0, 1'b0);
        chk("R2 low nibble", 64'(rd_tag), 64'h5);
        // R3 misaligned writes leave the store untouched
        run_cmd(1, 12'h031, 4'h3, 64'h0, 1'b0);
        run_cmd(2, 12'h048, 4'h3, 64'h0, 1'b0);
        run_cmd(0, 12'h030, 4'h0, 64'h0, 1'b0);
        chk("R3 no write", 64'(rd_tag), 64'hA);
        // R5 even pair, R6 odd pair across bytes 3 and 4
        run_cmd(2, 12'h040, 4'h7, 64'h0, 1'b0);
        run_cmd(1, 12'h060, 4'h9, 64'h0, 1'b0);
        run_cmd(1, 12'h090, 4'hC, 64'h0, 1'b0);
        run_cmd(2, 12'h070, 4'h3, 64'h0, 1'b0);
        run_cmd(3, 12'h0FF, 4'h0, 64'h0, 1'b0);
        chk("R5 even pair", 64'(rd_bulk[23:16]), 64'h77);
        chk("R6 odd pair first", 64'(rd_bulk[31:24]), 64'h39);
        chk("R6 odd pair second", 64'(rd_bulk[39:32]), 64'hC3);
        // R8 group write aligned down
        run_cmd(4, 12'h1F7, 4'h0, 64'h0123_4567_89AB_CDEF, 1'b0);
        run_cmd(3, 12'h100, 4'h0, 64'h0, 1'b0);
        chk("R8 group write", rd_bulk, 64'h0123_4567_89AB_CDEF);
        // R9 fill aligned down to the zeroing block
        run_cmd(5, 12'h2E5, 4'h6, 64'h0, 1'b0);
        run_cmd(3, 12'h200, 4'h0, 64'h0, 1'b0);
        chk("R9 fill", rd_bulk, 64'h6666_6666_0000_0000);
        // R10 region without tag storage
        run_cmd(1, 12'h020, 4'hF, 64'h0, 1'b1);
        run_cmd(5, 12'h000, 4'hE, 64'h0, 1'b1);
        run_cmd(4, 12'h100, 4'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        run_cmd(0, 12'h030, 4'h0, 64'h0, 1'b1);
        run_cmd(3, 12'h100, 4'h0, 64'h0, 1'b1);
        sweep("R10 writes dropped");

        // R11 command held while busy is not taken
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd4; cmd_addr = 12'h300; cmd_wdata = 64'h1122_3344_5566_7788;
        cmd_notag = 1'b0;
        model_apply(4, 12'h300, 4'h0, 64'h1122_3344_5566_7788);
        @(negedge clk);
        cmd_op = 3'd1; cmd_addr = 12'h300; cmd_tag = 4'hF;
        c = 0;
        while (!done && c < 100) begin
            @(negedge clk);
            c++;
        end
        cmd_valid = 1'b0;
        chk("R11 busy latency", 64'(c), 64'd8);
        sweep("R11 ignored while busy");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            op = int'($urandom % 6);
            a  = AW'($urandom);
            if ((op == 1 || op == 2) && ($urandom % 4 != 0)) a[3:0] = 4'h0;
            run_cmd(op, a, 4'($urandom), {$urandom, $urandom}, ($urandom % 8) == 0);
            if (i % 100 == 99) sweep("R4 R6 R8 R9 random store");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule